// File: doc/BRIEF.md
# Lazy Condition Flag Evaluator

This block rebuilds the condition flags of a processor's status word from a record of the last flag-setting operation. It receives the operation class, the operand size, the source and destination operands, the result, and the upper word of a multiply. From these it derives negative, zero, overflow and carry. It then merges them into the current status word under an update mask and returns the new status word one clock later.

Carry and overflow are taken only from the sign bits of the operands and the result, at the selected operand size. Subtract and compare invert the source sign before evaluation and invert the carry afterwards. The memory-copy class routes its carry term to a separate flag bit. When the extended-arithmetic bit is set, zero can be cleared but never set. The bit-test class follows its own rule and bypasses the mask merge.

Operation codes: 0 add, 1 subtract, 2 compare, 3 memory-copy, 4 move/logic/shift, 5 signed multiply, 6 unsigned multiply, 7 bit test. Size codes: 0 one byte, 1 two bytes, 2 and 3 four bytes. Status bit positions: C=0, V=1, Z=2, N=3, X=4, R=8.

Top module: `flag_eval`

## Requirements
- R1: For classes 0 to 4 evaluated by the sign rule, a set result sign bit at the operand size sets N. It also sets V when both operand signs are 0, or else sets C when both are 1.
- R2: With the result sign bit clear, Z is set when the size-masked result is zero, V is set when both operand signs are 1, and C is set when either operand sign is 1.
- R3: The sign bit is bit 7, 15 or 31 for size code 0, 1, or 2/3. Z looks only at the low 1, 2 or 4 bytes of the result.
- R4: Subtract (1) and compare (2) invert the source sign before the sign rule and invert C after it.
- R5: Memory-copy (3) always evaluates at four bytes without inversion. Its carry term goes to R (bit 8), and the computed C is 0.
- R6: Move (4) at size code 1, 2 or 3 sets only N or Z from the result, and the computed V and C are 0. At size code 0 it uses the sign rule of R1/R2.
- R7: Signed multiply (5) forms a 64-bit value {hi, res}. Z is set when the value is zero and N when bit 63 is set. V is set unless hi equals the sign extension of res bit 31.
- R8: Unsigned multiply (6) uses the same Z and N as R7 and sets V whenever hi is nonzero.
- R9: For classes 0 to 6, status bits outside the update mask OR X keep their current value. Bits inside take the computed flag.
- R10: For classes 0 to 6, when the X input is 1 and the computed Z is 1, Z is left at its current value, so a 0 stays 0.
- R11: For classes 0 to 6, the new X bit is always 0.
- R12: Bit test (7) selects bit src[4:0] of dst. N is set to that bit and Z is set when that bit and all lower bits are zero (index 31 covers the whole word). X is cleared, and all other bits keep their value regardless of the mask.
- R13: A synchronous active-high reset clears the output to 0. Otherwise the output is the new status for the inputs present at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation class code |
| size_i | input | 2 | Operand size code |
| src_i | input | 32 | Source operand |
| dst_i | input | 32 | Destination operand |
| res_i | input | 32 | Result (low word of a multiply) |
| hi_i | input | 32 | Upper word of a multiply |
| mask_i | input | 32 | Flag update mask |
| x_i | input | 1 | Extended-arithmetic state |
| stat_i | input | 32 | Current status word |
| stat_o | output | 32 | New status word, registered |

## Verification
Every result is due exactly one rising edge after its inputs are presented, because the only register on the path is the output register. The bench drives inputs at the falling edge and computes the expected word from its own behavioural model at that moment. It compares one time unit after the following rising edge, so each comparison matches exactly one stimulus. The reset value is checked while reset is held with nonzero inputs present.

// File: rtl/flag_pkg.sv
package flag_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_CMP  = 3'd2,
    OP_MCP  = 3'd3,
    OP_MOVE = 3'd4,
    OP_MULS = 3'd5,
    OP_MULU = 3'd6,
    OP_BTST = 3'd7
  } flag_op_e;

  localparam int FB_C = 0;
  localparam int FB_V = 1;
  localparam int FB_Z = 2;
  localparam int FB_N = 3;
  localparam int FB_X = 4;
  localparam int FB_R = 8;
endpackage

// File: rtl/sign_flags.sv
module sign_flags #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        size_i,
  input  logic              inv_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] res_i,
  output logic              n_o,
  output logic              z_o,
  output logic              v_o,
  output logic              c_o
);
  localparam int NBYTES = DATA_W / 8;

  logic [NBYTES-1:0] lane_zero;
  logic s_src, s_dst, s_res, zero_sz;

  genvar gi;
  generate
    for (gi = 0; gi < NBYTES; gi++) begin : g_lane
      assign lane_zero[gi] = (res_i[8*gi +: 8] == 8'h00);
    end
  endgenerate

  always_comb begin
    case (size_i)
      2'd0: begin
        s_src   = src_i[7];
        s_dst   = dst_i[7];
        s_res   = res_i[7];
        zero_sz = lane_zero[0];
      end
      2'd1: begin
        s_src   = src_i[15];
        s_dst   = dst_i[15];
        s_res   = res_i[15];
        zero_sz = &lane_zero[1:0];
      end
      default: begin
        s_src   = src_i[DATA_W-1];
        s_dst   = dst_i[DATA_W-1];
        s_res   = res_i[DATA_W-1];
        zero_sz = &lane_zero;
      end
    endcase
  end

  logic s_eff, c_raw;
  always_comb begin
    s_eff = s_src ^ inv_i;
    n_o   = s_res;
    if (s_res) begin
      z_o   = 1'b0;
      v_o   = ~s_eff & ~s_dst;
      c_raw = s_eff & s_dst;
    end else begin
      z_o   = zero_sz;
      v_o   = s_eff & s_dst;
      c_raw = s_eff | s_dst;
    end
    c_o = c_raw ^ inv_i;
  end
endmodule

// File: rtl/mul_flags.sv
module mul_flags #(
  parameter int DATA_W = 32
) (
  input  logic              signed_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  output logic              n_o,
  output logic              z_o,
  output logic              v_o
);
  logic [DATA_W-1:0] ext;
  always_comb begin
    ext = signed_i ? {DATA_W{lo_i[DATA_W-1]}} : '0;
    n_o = hi_i[DATA_W-1];
    z_o = (hi_i == '0) && (lo_i == '0);
    v_o = (hi_i != ext);
  end
endmodule

// File: rtl/btst_flags.sv
module btst_flags #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [DATA_W-1:0] sel_i,
  output logic              n_o,
  output logic              z_o
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] low_mask;

  assign idx = sel_i[IDX_W-1:0];

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_low
      assign low_mask[gi] = (gi <= int'(idx));
    end
  endgenerate

  assign n_o = word_i[idx];
  assign z_o = ((word_i & low_mask) == '0);
endmodule

// File: rtl/flag_eval.sv
module flag_eval
  import flag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [STAT_W-1:0] mask_i,
  input  logic              x_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic [STAT_W-1:0] stat_o
);
  localparam logic [STAT_W-1:0] XBIT = STAT_W'(1) << FB_X;
  localparam logic [STAT_W-1:0] ZBIT = STAT_W'(1) << FB_Z;
  localparam logic [STAT_W-1:0] BTST_CLR =
    (STAT_W'(1) << FB_X) | (STAT_W'(1) << FB_N) | (STAT_W'(1) << FB_Z);

  flag_op_e op;
  assign op = flag_op_e'(op_i);

  logic       inv;
  logic [1:0] eff_size;
  assign inv      = (op == OP_SUB) || (op == OP_CMP);
  assign eff_size = (op == OP_MCP) ? 2'd2 : size_i;

  logic a_n, a_z, a_v, a_c;
  sign_flags #(.DATA_W(DATA_W)) u_sign (
    .size_i (eff_size),
    .inv_i  (inv),
    .src_i  (src_i),
    .dst_i  (dst_i),
    .res_i  (res_i),
    .n_o    (a_n),
    .z_o    (a_z),
    .v_o    (a_v),
    .c_o    (a_c)
  );

  logic m_n, m_z, m_v;
  mul_flags #(.DATA_W(DATA_W)) u_mul (
    .signed_i (op == OP_MULS),
    .lo_i     (res_i),
    .hi_i     (hi_i),
    .n_o      (m_n),
    .z_o      (m_z),
    .v_o      (m_v)
  );

  logic b_n, b_z;
  btst_flags #(.DATA_W(DATA_W)) u_btst (
    .word_i (dst_i),
    .sel_i  (src_i),
    .n_o    (b_n),
    .z_o    (b_z)
  );

  logic [STAT_W-1:0] flags, wmask, merged, next_stat;

  always_comb begin
    flags = '0;
    case (op)
      OP_MULS, OP_MULU: begin
        flags[FB_N] = m_n;
        flags[FB_Z] = m_z;
        flags[FB_V] = m_v;
      end
      OP_MCP: begin
        flags[FB_N] = a_n;
        flags[FB_Z] = a_z;
        flags[FB_V] = a_v;
        flags[FB_R] = a_c;
      end
      OP_MOVE: begin
        flags[FB_N] = a_n;
        flags[FB_Z] = a_z;
        if (size_i == 2'd0) begin
          flags[FB_V] = a_v;
          flags[FB_C] = a_c;
        end
      end
      default: begin
        flags[FB_N] = a_n;
        flags[FB_Z] = a_z;
        flags[FB_V] = a_v;
        flags[FB_C] = a_c;
      end
    endcase
  end

  always_comb begin
    wmask = mask_i | XBIT;
    if (x_i && flags[FB_Z])
      wmask = wmask & ~ZBIT;
    merged = (stat_i & ~wmask) | (flags & wmask);
  end

  always_comb begin
    if (op == OP_BTST) begin
      next_stat = stat_i & ~BTST_CLR;
      next_stat[FB_N] = b_n;
      next_stat[FB_Z] = b_z;
    end else begin
      next_stat = merged;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stat_o <= '0;
    else     stat_o <= next_stat;
  end

  // R11
  x_clear_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> !stat_o[FB_X]);

  // R9
  unmasked_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (op != OP_BTST) |=>
      (((stat_o ^ $past(stat_i)) & ~($past(mask_i) | XBIT)) == '0));

  // R10
  ext_z_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (op != OP_BTST && x_i && !stat_i[FB_Z]) |=> !stat_o[FB_Z]);

  // R1
  sign_nz_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(a_n && a_z));

  // R12
  btst_nz_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(b_n && b_z));

  // R7
  mul_nz_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(m_n && m_z));
endmodule

// File: tb/tb_flag_eval.sv
module tb_flag_eval;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] src_i = '0, dst_i = '0, res_i = '0, hi_i = '0;
  logic [31:0] mask_i = '0, stat_i = '0;
  logic        x_i = 1'b0;
  logic [31:0] stat_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flag_eval dut (
    .clk(clk), .rst(rst), .op_i(op_i), .size_i(size_i),
    .src_i(src_i), .dst_i(dst_i), .res_i(res_i), .hi_i(hi_i),
    .mask_i(mask_i), .x_i(x_i), .stat_i(stat_i), .stat_o(stat_o)
  );

  function automatic logic [31:0] model(
    input logic [2:0] op, input logic [1:0] sz,
    input logic [31:0] s, input logic [31:0] d, input logic [31:0] r,
    input logic [31:0] h, input logic [31:0] m, input logic x,
    input logic [31:0] st);
    int bits;
    logic sub, ss, ds, rs, n, z, v, c, rf, zero;
    logic [63:0] full;
    logic [31:0] lm, msk, fl;
    n = 0; z = 0; v = 0; c = 0; rf = 0;
    if (op == 3'd7) begin
      lm = (s[4:0] == 5'd31) ? 32'hFFFF_FFFF : ((32'h1 << (s[4:0] + 1)) - 1);
      n = d[s[4:0]];
      z = ((d & lm) == 0);
      return (st & ~32'h1C) | (32'(n) << 3) | (32'(z) << 2);
    end
    if (op == 3'd5 || op == 3'd6) begin
      full = {h, r};
      z = (full == 0);
      n = full[63];
      if (op == 3'd5) v = (h != (r[31] ? 32'hFFFF_FFFF : 32'h0));
      else            v = (h != 0);
    end else begin
      bits = (op == 3'd3) ? 32 : (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
      sub  = (op == 3'd1 || op == 3'd2);
      ss   = s[bits-1] ^ sub;
      ds   = d[bits-1];
      rs   = r[bits-1];
      zero = (bits == 32) ? (r == 0) : ((r & ((32'h1 << bits) - 1)) == 0);
      if (op == 3'd4 && sz != 2'd0) begin
        n = rs;
        z = !rs && zero;
      end else begin
        if (rs) begin n = 1; v = !ss && !ds; c = ss && ds; end
        else    begin z = zero; v = ss && ds; c = ss || ds; end
        if (sub) c = !c;
        if (op == 3'd3) begin rf = c; c = 0; end
      end
    end
    fl  = (32'(rf) << 8) | (32'(n) << 3) | (32'(z) << 2) | (32'(v) << 1) | 32'(c);
    msk = m | 32'h10;
    if (x && z) msk = msk & ~32'h4;
    return (st & ~msk) | (fl & msk);
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R1/R2";
      3'd1, 3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic apply(input string tag, input logic [2:0] op, input logic [1:0] sz,
                       input logic [31:0] s, input logic [31:0] d, input logic [31:0] r,
                       input logic [31:0] h, input logic [31:0] m, input logic x,
                       input logic [31:0] st);
    logic [31:0] exp_v;
    @(negedge clk);
    op_i = op; size_i = sz; src_i = s; dst_i = d; res_i = r; hi_i = h;
    mask_i = m; x_i = x; stat_i = st;
    exp_v = model(op, sz, s, d, r, h, m, x, st);
    @(posedge clk);
    #1;
    checks++;
    if (stat_o !== exp_v) begin
      errors++;
      $display("FAIL %s: op=%0d actual=%h expected=%h", tag, op, stat_o, exp_v);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R13: reset holds output at zero despite live inputs
    op_i = 3'd0; res_i = 32'h8000_0000; mask_i = 32'hFFFF_FFFF; stat_i = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (stat_o !== 32'h0) begin
      errors++;
      $display("FAIL R13: actual=%h expected=%h", stat_o, 32'h0);
    end
    @(negedge clk);
    rst = 1'b0;

    // R1: negative result, both signs clear -> N,V
    apply("R1", 3'd0, 2'd2, 32'h1, 32'h2, 32'h8000_0000, 0, 32'hF, 0, 0);
    apply("R1", 3'd0, 2'd2, 32'h8000_0000, 32'h8000_0001, 32'h8000_0000, 0, 32'hF, 0, 0);
    // R2: zero result with both signs set -> Z,V,C
    apply("R2", 3'd0, 2'd2, 32'h8000_0000, 32'h8000_0000, 32'h0, 0, 32'hF, 0, 0);
    // R3: byte size sees only the low byte
    apply("R3", 3'd0, 2'd0, 32'h80, 32'h80, 32'h0000_0100, 0, 32'hF, 0, 0);
    apply("R3", 3'd0, 2'd1, 32'h1, 32'h2, 32'h0000_8000, 0, 32'hF, 0, 0);
    // R4: subtract/compare invert source sign and carry
    apply("R4", 3'd1, 2'd2, 32'h1, 32'h1, 32'h0, 0, 32'hF, 0, 0);
    apply("R4", 3'd2, 2'd0, 32'h7F, 32'h01, 32'h82, 0, 32'hF, 0, 32'h0);
    // R5: memory-copy carry goes to R
    apply("R5", 3'd3, 2'd0, 32'h8000_0000, 32'h0, 32'h1, 0, 32'h10F, 0, 32'h1);
    // R6: move sets only N/Z at 2 and 4 bytes
    apply("R6", 3'd4, 2'd1, 32'h8000, 32'h8000, 32'h5, 0, 32'hF, 0, 32'h3);
    apply("R6", 3'd4, 2'd0, 32'h80, 32'h80, 32'h0, 0, 32'hF, 0, 0);
    // R7: signed multiply, proper extension vs not
    apply("R7", 3'd5, 2'd2, 0, 0, 32'h8000_0000, 32'hFFFF_FFFF, 32'hF, 0, 0);
    apply("R7", 3'd5, 2'd2, 0, 0, 32'h0000_0001, 32'hFFFF_FFFF, 32'hF, 0, 0);
    // R8: unsigned multiply overflow on nonzero high word
    apply("R8", 3'd6, 2'd2, 0, 0, 32'h0, 32'h1, 32'hF, 0, 0);
    // R9: bits outside the mask keep their value
    apply("R9", 3'd0, 2'd2, 32'h1, 32'h2, 32'h8000_0000, 0, 32'h1, 0, 32'hFFFF_FFE0);
    // R10: extended mode cannot set Z
    apply("R10", 3'd0, 2'd2, 0, 0, 32'h0, 0, 32'hF, 1, 32'h0);
    apply("R10", 3'd0, 2'd2, 0, 0, 32'h0, 0, 32'hF, 1, 32'h4);
    // R11: X cleared with an empty mask
    apply("R11", 3'd4, 2'd2, 0, 0, 32'h5, 0, 32'h0, 0, 32'h1F);
    // R12: bit test at several indices, mask ignored
    apply("R12", 3'd7, 2'd2, 32'd4, 32'h10, 0, 0, 32'h0, 0, 32'h13);
    apply("R12", 3'd7, 2'd2, 32'd3, 32'h10, 0, 0, 32'h0, 0, 32'h3);
    apply("R12", 3'd7, 2'd2, 32'd31, 32'h0, 0, 0, 32'hFFFF_FFFF, 0, 32'hFF);
    apply("R12", 3'd7, 2'd2, 32'd31, 32'h8000_0000, 0, 0, 32'h0, 0, 32'h0);

    for (int i = 0; i < 3000; i++) begin
      logic [2:0]  rop;
      logic [31:0] rr, rh, rs, rd;
      rop = 3'($urandom_range(0, 7));
      rr  = $urandom;
      rs  = $urandom;
      rd  = $urandom;
      if ((i % 5) == 0) rr = rr & 32'hFFFF_0000;
      if ((i % 7) == 0) rr = 32'h0;
      rh  = ((i % 3) == 0) ? (rr[31] ? 32'hFFFF_FFFF : 32'h0) : $urandom;
      if ((i % 11) == 0) rh = 32'h0;
      apply(tag_of(rop), rop, 2'($urandom_range(0, 3)), rs, rd, rr, rh,
            $urandom, 1'($urandom_range(0, 1)), $urandom);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule